// File: doc/BRIEF.md
# Multi-Mode Countdown Timer Channel

One countdown channel of a timer bank. A down-counter runs in one of four modes. It can count freely as a 32-bit periodic timer. It can run as two 16-bit halves in sequence, with a pre-trigger level between them. It can count trigger edges, or it can free-run from all ones and record the inverse of the count when a trigger edge arrives. On expiry the channel emits a one-cycle timeout pulse and a matching flag-set strobe, and it reloads in the same step.

The surrounding logic supplies the settings as plain inputs: the load value, the mode, the trigger, the previous channel's timeout (for chaining), an enable, and three option bits. Those bits make the channel wait for a trigger before counting, reload when a trigger arrives, or halt after an expiry. The register file, the trigger routing between channels and the interrupt merge are outside this block.

Top module: `cdown_chan`

## Requirements
- R1: While reset is held and after it is released, with the channel disabled, the count and the captured value read 0 and the timeout, pre-trigger and flag-set outputs are low.
- R2: In mode 0 (periodic), a rising enable loads the load value. The count then drops by one per clock. In the cycle in which the count is 0, the timeout output is high for exactly that cycle, and the next cycle shows the load value again.
- R3: A change of the load value while counting does not disturb the current count. The new value appears only at the reload that follows the next expiry.
- R4: In mode 1 (split), the lower half, bits [W/2-1:0], counts down first. Once it is zero, the pre-trigger output is high and the upper half counts down. The timeout fires when both halves are zero, and the reload drops the pre-trigger.
- R5: In mode 2 (accumulate), the clock alone never changes the count. The first trigger edge loads the load value, each later edge lowers it by one, and an edge that arrives at zero produces the timeout and a reload.
- R6: In mode 3 (capture), the counter starts from all ones and counts down. A trigger edge stores the bitwise inverse of that cycle's count in the captured value, which otherwise holds.
- R7: With chaining set (in modes other than accumulate), the count changes only in cycles where the chain input is high.
- R8: With start-on-trigger set, an enabled channel holds its loaded count until a trigger edge arrives and counts normally after it.
- R9: With reload-on-trigger set (in modes other than accumulate), a trigger edge while counting reloads the load value instead of decrementing.
- R10: With stop-on-timeout set, the channel reloads at expiry and then holds with no further timeout until a trigger edge or a fresh enable restarts it.
- R11: The trigger is edge-detected: a trigger held high for several cycles counts as one event.
- R12: While enable is low the count holds and no timeout is produced, even at zero. A later rising enable starts from a fresh load.
- R13: The flag-set strobe is high in exactly the cycles in which the timeout pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Channel enable; a rising edge loads the counter |
| mode_i | input | 2 | 0 periodic, 1 split, 2 accumulate, 3 capture |
| load_val_i | input | W | Reload value |
| trig_i | input | 1 | Trigger level; its rising edge is the event |
| chain_i | input | 1 | Timeout of the previous channel |
| opt_chain_i | input | 1 | Count only on chain_i |
| opt_start_i | input | 1 | Wait for a trigger before counting |
| opt_reload_i | input | 1 | Reload when a trigger arrives |
| opt_stop_i | input | 1 | Halt after an expiry |
| count_o | output | W | Live counter value |
| capture_o | output | W | Inverted count captured at a trigger |
| timeout_o | output | 1 | One-cycle expiry pulse |
| pretrig_o | output | 1 | Split mode: lower half done, upper counting |
| flag_set_o | output | 1 | Request to set the timeout flag |

## Verification
A wrong run state or a missed edge shows at the ports within one cycle: count_o either moves when it should hold or holds when it should move. A wrong reload source appears on count_o in the cycle after the timeout pulse. A faulty split borrow shows as the upper half changing while the pre-trigger is low, or as the pre-trigger staying high after the reload. A capture error is visible on capture_o one cycle after the trigger edge.

// File: rtl/cdown_pkg.sv
// Shared types for the countdown channel.
package cdown_pkg;
    typedef enum logic [1:0] {
        MODE_PERIODIC = 2'd0,
        MODE_SPLIT    = 2'd1,
        MODE_ACCUM    = 2'd2,
        MODE_CAPTURE  = 2'd3
    } cd_mode_e;
endpackage

// File: rtl/cdown_edge.sv
// Rising-edge detector for N independent level inputs.
// Assumes inputs are synchronous to clk.
module cdown_edge #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] sig_q;

    // Remember the previous level of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/cdown_ctrl.sv
// Run control for one countdown channel: decides each cycle whether the
// counter loads, decrements or expires, and tracks the running state.
// Assumes trig_evt_i and en_rise_i are single-cycle edge events.
module cdown_ctrl
    import cdown_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable_i,
    input  logic     en_rise_i,
    input  logic     trig_evt_i,
    input  logic     chain_i,
    input  logic     opt_chain_i,
    input  logic     opt_start_i,
    input  logic     opt_reload_i,
    input  logic     opt_stop_i,
    input  cd_mode_e mode_i,
    input  logic     cnt_zero_i,
    output logic     running_o,
    output logic     load_o,
    output logic     dec_o,
    output logic     expire_o,
    output logic     cap_o
);
    logic running_q;
    logic tick, live, restart, trig_reload;

    // Count step source: trigger edges in accumulate mode, else chain or clock.
    always_comb begin
        if (mode_i == MODE_ACCUM) tick = trig_evt_i;
        else if (opt_chain_i)     tick = chain_i;
        else                      tick = 1'b1;
    end

    // Per-cycle decisions; a trigger reload takes priority over a step.
    always_comb begin
        live        = enable_i && running_q && !en_rise_i;
        restart     = enable_i && !en_rise_i && !running_q && trig_evt_i;
        trig_reload = live && trig_evt_i && opt_reload_i && (mode_i != MODE_ACCUM);
        expire_o    = live && !trig_reload && tick && cnt_zero_i;
        dec_o       = live && !trig_reload && tick && !cnt_zero_i;
        load_o      = en_rise_i || restart || trig_reload || expire_o;
        cap_o       = live && trig_evt_i && (mode_i == MODE_CAPTURE);
    end

    // Running state: set on enable or trigger restart, cleared on disable or stop.
    always_ff @(posedge clk) begin
        if (!rst_n)                      running_q <= 1'b0;
        else if (en_rise_i)              running_q <= !opt_start_i && (mode_i != MODE_ACCUM);
        else if (!enable_i)              running_q <= 1'b0;
        else if (restart)                running_q <= 1'b1;
        else if (expire_o && opt_stop_i) running_q <= 1'b0;
    end

    assign running_o = running_q;

    // R5: without a trigger edge the accumulator neither steps nor expires.
    a_r5_accum_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_ACCUM && !trig_evt_i) |-> (!dec_o && !expire_o));

    // R10: an expiry with stop set is not followed by another expiry.
    a_r10_halt_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && opt_stop_i) |=> !expire_o);

    // R12: a disabled channel takes no counting action.
    a_r12_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> (!dec_o && !expire_o && !load_o));
endmodule

// File: rtl/cdown_count.sv
// Counter datapath: loads the reload value (or all ones), and decrements
// either as one W-bit value or as two halves, lower half first.
// Assumes W is even.
module cdown_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         dec_i,
    input  logic         split_i,
    input  logic         fill_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o,
    output logic         lo_zero_o
);
    localparam int H = W / 2;
    localparam logic [H-1:0] ONE_H = H'(1);
    localparam logic [W-1:0] ONE_W = W'(1);

    logic [W-1:0] cnt_q, init_val, dec_val;
    logic [H-1:0] lo, hi;

    assign lo = cnt_q[H-1:0];
    assign hi = cnt_q[W-1:H];

    // Reload source: all ones in capture mode, else the load value.
    always_comb init_val = fill_i ? '1 : load_val_i;

    // Next value on a step: whole decrement or lower-half-first split.
    always_comb begin
        if (split_i) begin
            if (lo != '0) dec_val = {hi, lo - ONE_H};
            else          dec_val = {hi - ONE_H, lo};
        end else begin
            dec_val = cnt_q - ONE_W;
        end
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= init_val;
        else if (dec_i)  cnt_q <= dec_val;
    end

    assign cnt_o     = cnt_q;
    assign zero_o    = (cnt_q == '0);
    assign lo_zero_o = (lo == '0);

    // R2: a load places the selected reload value in the counter.
    a_r2_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(init_val)));

    // R4: in split mode the upper half holds while the lower half runs.
    a_r4_upper_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (split_i && dec_i && !load_i && lo != '0) |=> (cnt_q[W-1:H] == $past(hi)));
endmodule

// File: rtl/cdown_capt.sv
// Capture register: stores the inverted count on a capture event.
module cdown_capt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  logic [W-1:0] cnt_i,
    output logic [W-1:0] capture_o
);
    logic [W-1:0] cap_q;

    // Hold the inverse of the count seen at a capture event.
    always_ff @(posedge clk) begin
        if (!rst_n)     cap_q <= '0;
        else if (cap_i) cap_q <= ~cnt_i;
    end

    assign capture_o = cap_q;

    // R6: the captured value changes only on a capture event.
    a_r6_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(cap_q));
endmodule

// File: rtl/cdown_chan.sv
// One countdown timer channel with periodic, split, accumulate and capture
// modes. Assumes all inputs are synchronous to clk and W is even.
module cdown_chan
    import cdown_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable_i,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] load_val_i,
    input  logic         trig_i,
    input  logic         chain_i,
    input  logic         opt_chain_i,
    input  logic         opt_start_i,
    input  logic         opt_reload_i,
    input  logic         opt_stop_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] capture_o,
    output logic         timeout_o,
    output logic         pretrig_o,
    output logic         flag_set_o
);
    cd_mode_e mode;
    logic [1:0] rises;
    logic en_rise, trig_evt;
    logic running, load, dec, expire, cap, cnt_zero, lo_zero;

    assign mode = cd_mode_e'(mode_i);

    cdown_edge #(.N(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  ({trig_i, enable_i}),
        .rise_o (rises)
    );
    assign en_rise  = rises[0];
    assign trig_evt = rises[1];

    cdown_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .en_rise_i    (en_rise),
        .trig_evt_i   (trig_evt),
        .chain_i      (chain_i),
        .opt_chain_i  (opt_chain_i),
        .opt_start_i  (opt_start_i),
        .opt_reload_i (opt_reload_i),
        .opt_stop_i   (opt_stop_i),
        .mode_i       (mode),
        .cnt_zero_i   (cnt_zero),
        .running_o    (running),
        .load_o       (load),
        .dec_o        (dec),
        .expire_o     (expire),
        .cap_o        (cap)
    );

    cdown_count #(.W(W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .dec_i      (dec),
        .split_i    (mode == MODE_SPLIT),
        .fill_i     (mode == MODE_CAPTURE),
        .load_val_i (load_val_i),
        .cnt_o      (count_o),
        .zero_o     (cnt_zero),
        .lo_zero_o  (lo_zero)
    );

    cdown_capt #(.W(W)) u_capt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_i     (cap),
        .cnt_i     (count_o),
        .capture_o (capture_o)
    );

    // Expiry drives both the trigger pulse and the flag request.
    assign timeout_o  = expire;
    assign flag_set_o = expire;
    assign pretrig_o  = enable_i && running && (mode == MODE_SPLIT) && lo_zero;

    // R4: the pre-trigger level exists only in split mode.
    a_r4_pretrig_split_only: assert property (@(posedge clk) disable iff (!rst_n)
        pretrig_o |-> (mode == MODE_SPLIT));

    // R12: the count holds across a disabled cycle.
    a_r12_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> $stable(count_o));
endmodule

// File: tb/sim_cdown_chan.sv
module sim_cdown_chan;
    localparam int K_CNT = 0, K_CAP = 1, K_TO = 2, K_PRE = 3, K_FLG = 4;

    typedef struct {
        int          cyc;
        int          kind;
        logic [31:0] val;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [31:0] load_val = '0;
    logic        trig = 1'b0, chain = 1'b0;
    logic        o_chain = 1'b0, o_start = 1'b0, o_reload = 1'b0, o_stop = 1'b0;
    logic [31:0] count, capture;
    logic        timeout, pretrig, flag_set;

    item_t sb[$];
    int cyc = 0, n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cdown_chan #(.W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .mode_i(mode),
        .load_val_i(load_val), .trig_i(trig), .chain_i(chain),
        .opt_chain_i(o_chain), .opt_start_i(o_start), .opt_reload_i(o_reload),
        .opt_stop_i(o_stop), .count_o(count), .capture_o(capture),
        .timeout_o(timeout), .pretrig_o(pretrig), .flag_set_o(flag_set)
    );

    function automatic logic [31:0] pick(int k);
        case (k)
            K_CNT:   return count;
            K_CAP:   return capture;
            K_TO:    return {31'd0, timeout};
            K_PRE:   return {31'd0, pretrig};
            default: return {31'd0, flag_set};
        endcase
    endfunction

    // Driver side: expect a value in the sample of the current cycle.
    task automatic e(int kind, logic [31:0] val, string req);
        item_t it;
        it.cyc = cyc + 1; it.kind = kind; it.val = val; it.req = req;
        sb.push_back(it);
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    // Monitor: samples before the rising edge and pops due items.
    always @(negedge clk) begin
        item_t it;
        logic [31:0] act;
        #3;
        cyc++;
        while (sb.size() > 0 && sb[0].cyc == cyc) begin
            it  = sb.pop_front();
            act = pick(it.kind);
            n_chk++;
            if (act !== it.val) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.val);
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e(K_CNT, 0, "R1"); e(K_CAP, 0, "R1"); e(K_TO, 0, "R1");
        e(K_PRE, 0, "R1"); e(K_FLG, 0, "R1");
        nxt();
        e(K_CNT, 0, "R1"); nxt();

        // R2, R3, R13: periodic count, deferred load value
        mode = 2'd0; load_val = 3; enable = 1'b1; nxt();
        e(K_CNT, 3, "R2"); e(K_TO, 0, "R2"); nxt();
        e(K_CNT, 2, "R2"); load_val = 5; nxt();
        e(K_CNT, 1, "R3"); nxt();
        e(K_CNT, 0, "R2"); e(K_TO, 1, "R2"); e(K_FLG, 1, "R13"); nxt();
        e(K_CNT, 5, "R3"); e(K_TO, 0, "R2"); e(K_FLG, 0, "R13"); nxt();
        e(K_CNT, 4, "R2"); enable = 1'b0; nxt();
        // R12: hold while off, fresh load on re-enable, no pulse at zero
        e(K_CNT, 4, "R12"); nxt();
        e(K_CNT, 4, "R12"); enable = 1'b1; nxt();
        e(K_CNT, 5, "R12"); enable = 1'b0; nxt();
        load_val = 1; enable = 1'b1; nxt();
        e(K_CNT, 1, "R12"); nxt();
        enable = 1'b0; e(K_CNT, 0, "R12"); e(K_TO, 0, "R12"); nxt();
        e(K_CNT, 0, "R12"); e(K_TO, 0, "R12"); e(K_FLG, 0, "R12"); nxt();

        // R4: split halves with pre-trigger
        mode = 2'd1; load_val = 32'h0002_0002; enable = 1'b1; nxt();
        e(K_CNT, 32'h0002_0002, "R4"); e(K_PRE, 0, "R4"); nxt();
        e(K_CNT, 32'h0002_0001, "R4"); e(K_PRE, 0, "R4"); nxt();
        e(K_CNT, 32'h0002_0000, "R4"); e(K_PRE, 1, "R4"); nxt();
        e(K_CNT, 32'h0001_0000, "R4"); e(K_PRE, 1, "R4"); e(K_TO, 0, "R4"); nxt();
        e(K_CNT, 32'h0000_0000, "R4"); e(K_PRE, 1, "R4"); e(K_TO, 1, "R4"); nxt();
        e(K_CNT, 32'h0002_0002, "R4"); e(K_PRE, 0, "R4"); e(K_TO, 0, "R4");
        enable = 1'b0; nxt();

        // R5, R11: trigger accumulation with edge detection
        mode = 2'd2; load_val = 2; enable = 1'b1; nxt();
        e(K_CNT, 2, "R5"); nxt();
        e(K_CNT, 2, "R5"); trig = 1'b1; nxt();
        e(K_CNT, 2, "R11"); nxt();
        e(K_CNT, 2, "R11"); trig = 1'b0; nxt();
        e(K_CNT, 2, "R5"); trig = 1'b1; nxt();
        e(K_CNT, 1, "R5"); trig = 1'b0; nxt();
        e(K_CNT, 1, "R5"); trig = 1'b1; nxt();
        e(K_CNT, 0, "R5"); e(K_TO, 0, "R5"); trig = 1'b0; nxt();
        trig = 1'b1; e(K_CNT, 0, "R5"); e(K_TO, 1, "R5"); nxt();
        trig = 1'b0; e(K_CNT, 2, "R5"); e(K_TO, 0, "R5"); enable = 1'b0; nxt();

        // R6: input capture of the inverted count
        mode = 2'd3; enable = 1'b1; nxt();
        e(K_CNT, 32'hFFFF_FFFF, "R6"); nxt();
        e(K_CNT, 32'hFFFF_FFFE, "R6"); e(K_CAP, 0, "R6"); nxt();
        e(K_CNT, 32'hFFFF_FFFD, "R6"); trig = 1'b1; nxt();
        e(K_CNT, 32'hFFFF_FFFC, "R6"); e(K_CAP, 32'h0000_0002, "R6"); trig = 1'b0; nxt();
        e(K_CNT, 32'hFFFF_FFFB, "R6"); e(K_CAP, 32'h0000_0002, "R6"); enable = 1'b0; nxt();

        // R9: reload on trigger
        mode = 2'd0; load_val = 10; o_reload = 1'b1; enable = 1'b1; nxt();
        e(K_CNT, 10, "R9"); nxt();
        e(K_CNT, 9, "R9"); nxt();
        e(K_CNT, 8, "R9"); trig = 1'b1; nxt();
        e(K_CNT, 10, "R9"); trig = 1'b0; nxt();
        e(K_CNT, 9, "R9"); enable = 1'b0; o_reload = 1'b0; nxt();

        // R8: start on trigger
        load_val = 4; o_start = 1'b1; enable = 1'b1; nxt();
        e(K_CNT, 4, "R8"); nxt();
        e(K_CNT, 4, "R8"); nxt();
        e(K_CNT, 4, "R8"); trig = 1'b1; nxt();
        e(K_CNT, 4, "R8"); trig = 1'b0; nxt();
        e(K_CNT, 3, "R8"); nxt();
        e(K_CNT, 2, "R8"); enable = 1'b0; o_start = 1'b0; nxt();

        // R10: stop after expiry, restart by trigger
        load_val = 1; o_stop = 1'b1; enable = 1'b1; nxt();
        e(K_CNT, 1, "R10"); nxt();
        e(K_CNT, 0, "R10"); e(K_TO, 1, "R10"); nxt();
        e(K_CNT, 1, "R10"); e(K_TO, 0, "R10"); nxt();
        e(K_CNT, 1, "R10"); e(K_TO, 0, "R10"); nxt();
        e(K_CNT, 1, "R10"); trig = 1'b1; nxt();
        e(K_CNT, 1, "R10"); trig = 1'b0; nxt();
        e(K_CNT, 0, "R10"); e(K_TO, 1, "R10"); nxt();
        e(K_CNT, 1, "R10"); enable = 1'b0; o_stop = 1'b0; nxt();

        // R7: chained counting
        load_val = 2; o_chain = 1'b1; enable = 1'b1; nxt();
        e(K_CNT, 2, "R7"); nxt();
        e(K_CNT, 2, "R7"); chain = 1'b1; nxt();
        e(K_CNT, 1, "R7"); chain = 1'b0; nxt();
        e(K_CNT, 1, "R7"); chain = 1'b1; nxt();
        e(K_CNT, 0, "R7"); e(K_TO, 1, "R7"); nxt();
        chain = 1'b0; e(K_CNT, 2, "R7"); e(K_TO, 0, "R7"); enable = 1'b0; nxt();

        nxt();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule